// File: doc/BRIEF.md
# Predicated Vector Element Issue Sequencer

This block turns one vectorised instruction into a stream of scalar element operations aimed at consecutive registers of the ordinary register file. A start handshake hands it a base register, an element count, a predicate mask, a completion mask and a fault-handling mode. It then offers element operations one at a time, in rising index order, on an issue handshake. Element i always names register base+i, so a single load or store moves a whole contiguous run of registers. Elements that are masked off by the predicate, or that are already marked complete, are never offered and use no issue cycle. Their destination registers keep whatever they held.

The downstream unit answers each accepted element with a fault bit in the same cycle. Two modes are available. In precise mode the first fault ends the instruction: every lower element has finished, nothing from the faulting element onward is executed, and its index is reported. In deferred mode a fault only marks the element in a fault mask and issue carries on. The fault is signalled once the last element has gone. Software can then fix the cause and restart the instruction, passing the elements that succeeded as the completion mask so that they are not performed a second time.

When the instruction ends, a single-cycle done pulse is raised. The fault flag, the lowest faulting index and the full fault mask stay valid until the next instruction is accepted.

Top module: `vec_elem_sequencer`

## Requirements
- R1: After reset, start_ready is 1, and issue_valid, done, fault_flag, fault_idx and fault_mask are all 0.
- R2: An instruction is accepted at a clock edge where start_valid and start_ready are both 1. start_ready stays 0 from that edge until the edge at which done is raised.
- R3: The element with index i is offered with issue_idx = i and issue_reg = (base + i) mod 2^REG_AW, so the register number wraps past the top of the register file.
- R4: Elements are offered in strictly ascending index order. Each element is consumed by exactly one handshake (issue_valid and issue_ready high at an edge). Only indices below the element count are offered, and a count above MAX_VL is treated as MAX_VL.
- R5: An element whose bit in start_pred is 0 is never offered. An all-zero predicate offers no element at all.
- R6: An element whose bit in start_skip (the completion mask) is 1 is never offered.
- R7: Skipped elements take no cycle. With issue_ready held at 1, the n enabled elements are offered on n consecutive cycles, the first on the cycle after acceptance, and done is high on cycle n+1 after acceptance.
- R8: A count of 0, or a combination of masks that leaves no element enabled, raises done on the cycle after acceptance, with fault_flag 0 and no element offered.
- R9: In precise mode (start_defer = 0), a fault on the handshake of element j ends the instruction. No further element is offered, done is high on the next cycle, and the outputs are fault_flag = 1, fault_idx = j and fault_mask with only bit j set.
- R10: In deferred mode (start_defer = 1), faults set the element's fault_mask bit and issue goes on to the last enabled element. Done follows that element's handshake. fault_flag = 1 exactly when some bit of fault_mask is set, and fault_idx is the lowest faulting index, or 0 when there is none.
- R11: done is high for a single cycle, and only on the cycle after the final handshake, or after acceptance when no element is enabled. fault_flag, fault_idx and fault_mask keep their values until the next instruction is accepted.
- R12: While issue_valid is 1 and issue_ready is 0, the next cycle still has issue_valid = 1 with issue_idx unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Instruction offered |
| start_ready | output | 1 | Sequencer idle, can accept an instruction |
| start_vl | input | CNT_W | Element count |
| start_base | input | REG_AW | First register of the run |
| start_pred | input | MAX_VL | Predicate mask, bit i enables element i |
| start_skip | input | MAX_VL | Completion mask, bit i marks element i as already done |
| start_defer | input | 1 | 1 selects deferred fault mode, 0 selects precise mode |
| issue_valid | output | 1 | An element operation is offered |
| issue_ready | input | 1 | Downstream accepts the offered element |
| issue_idx | output | IDX_W | Index of the offered element |
| issue_reg | output | REG_AW | Register targeted by the offered element |
| issue_fault | input | 1 | Fault response for the element accepted this cycle |
| done | output | 1 | One-cycle end-of-instruction pulse |
| fault_flag | output | 1 | At least one element faulted |
| fault_idx | output | IDX_W | Lowest faulting element index |
| fault_mask | output | MAX_VL | One bit for each faulting element |

## Verification
Directed cases cover the following, each separating one behaviour from its neighbours:
- a zero count and an all-zero predicate, which must end without any issue;
- a sparse predicate under a ready signal that never drops, which shows that gaps cost no cycles;
- a base near the top of the register file, which exposes any missing wrap;
- a count above the maximum, which tests the clamp;
- one fault in precise mode against several faults in deferred mode, which tells a halting sequence from a continuing one;
- a rerun whose completion mask is the complement of the earlier fault mask, which must replay only the failed elements.

Random instructions then mix every count, base, predicate density, completion mask, fault pattern and mode under three ready duty cycles. The bench checks every handshake against the expected element order and register. It also checks the stall hold, the done timing and the final fault report.

// File: rtl/vseq_pkg.sv
// Package: vseq_pkg
// Shared types for the vector element issue sequencer.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package vseq_pkg;

    // Control state of the sequencer
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vseq_state_e;

    // Fault handling mode captured at instruction start
    typedef enum logic {
        MODE_PRECISE = 1'b0,
        MODE_DEFER   = 1'b1
    } vseq_mode_e;

endpackage

// File: rtl/vseq_enable_mask.sv
// Module: vseq_enable_mask
// Works out which elements of an instruction take part. An element is enabled
// when its index is below the count, its predicate bit is set and its
// completion bit is clear. Counts above N enable every index, which clamps
// them to N.
// Assumes CW is wide enough to hold N.
module vseq_enable_mask #(
    parameter int N  = 32,
    parameter int CW = 6
) (
    input  logic [CW-1:0] vl,
    input  logic [N-1:0]  pred,
    input  logic [N-1:0]  skip,
    output logic [N-1:0]  en
);

    // One enable term per element position
    for (genvar i = 0; i < N; i++) begin : g_en
        assign en[i] = pred[i] & ~skip[i] & (CW'(i) < vl);
    end

endmodule

// File: rtl/vseq_lowest_pick.sv
// Module: vseq_lowest_pick
// Finds the lowest set bit of a request vector. It gives a one-hot grant,
// the binary index of that bit, and a flag that is set when any bit is set.
// Assumes N >= 2 and IW = clog2(N). Purely combinational.
module vseq_lowest_pick #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);

    logic [N:0] below;

    assign below[0] = 1'b0;

    // Prefix chain: below[i] is set when a lower request exists
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign below[i+1] = below[i] | req[i];
        assign onehot[i]  = req[i] & ~below[i];
    end

    assign any = below[N];

    // Encode the one-hot grant into a binary index
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) begin
                idx = idx | IW'(i);
            end
        end
    end

endmodule

// File: rtl/vseq_fault_log.sv
// Module: vseq_fault_log
// Keeps the fault report of the current instruction: one mask bit for each
// faulting element, a summary flag, and the index of the first recorded
// fault. Elements arrive in ascending order, so the first recorded index is
// also the lowest.
// Assumes clear and rec never occur together, because clear only happens
// while the sequencer is idle.
module vseq_fault_log #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          rec,
    input  logic [IW-1:0] rec_idx,
    output logic          fault_flag,
    output logic [IW-1:0] fault_idx,
    output logic [N-1:0]  fault_mask
);

    // Clear on a new instruction, otherwise accumulate faulting elements
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_flag <= 1'b0;
            fault_idx  <= '0;
            fault_mask <= '0;
        end else if (clear) begin
            fault_flag <= 1'b0;
            fault_idx  <= '0;
            fault_mask <= '0;
        end else if (rec) begin
            fault_mask[rec_idx] <= 1'b1;
            if (!fault_flag) begin
                fault_flag <= 1'b1;
                fault_idx  <= rec_idx;
            end
        end
    end

    // The reported first fault must be one of the recorded faults
    assert_first_in_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> fault_mask[fault_idx]);

    // A later fault never replaces the first reported index
    assert_first_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag && !clear |=> fault_flag && fault_idx == $past(fault_idx));

    // The report holds between instructions while nothing is recorded
    assert_report_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !clear && !rec |=> $stable(fault_mask) && $stable(fault_idx) && $stable(fault_flag));

endmodule

// File: rtl/vseq_ctrl.sv
// Module: vseq_ctrl
// Sequencing control. It accepts an instruction while idle and captures the
// enabled-element set, base register and fault mode. It then offers the
// lowest pending element on each cycle, retires it on a handshake and ends
// when nothing is pending or when a precise-mode fault occurs. The done pulse
// goes out on the cycle after the final handshake.
// Assumes the pick inputs are driven from the pend output by a lowest-bit
// selector.
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int N  = 32,
    parameter int IW = 5,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_valid,
    output logic          start_ready,
    input  logic [N-1:0]  en_mask,
    input  logic [AW-1:0] start_base,
    input  logic          start_defer,
    output logic          issue_valid,
    input  logic          issue_ready,
    output logic [IW-1:0] issue_idx,
    output logic [AW-1:0] issue_reg,
    input  logic          issue_fault,
    output logic [N-1:0]  pend,
    input  logic          pick_any,
    input  logic [IW-1:0] pick_idx,
    input  logic [N-1:0]  pick_oh,
    output logic          done,
    output logic          log_clear,
    output logic          log_rec
);

    vseq_state_e   state;
    vseq_mode_e    mode_q;
    logic [AW-1:0] base_q;
    logic [N-1:0]  en_q;
    logic          done_q;
    logic          hs;
    logic          accept;
    logic [N-1:0]  pend_next;
    logic          finish;

    // Handshake and accept strobes
    always_comb begin
        start_ready = (state == ST_IDLE);
        accept      = start_ready & start_valid;
        issue_valid = (state == ST_RUN) & pick_any;
        hs          = issue_valid & issue_ready;
    end

    // Remaining work after the current handshake, and whether this ends it
    always_comb begin
        pend_next = pend & ~pick_oh;
        finish    = (pend_next == '0) | (issue_fault & (mode_q == MODE_PRECISE));
    end

    // Element address: index offset from the captured base, wrapping
    always_comb begin
        issue_idx = pick_idx;
        issue_reg = base_q + AW'(pick_idx);
    end

    // Strobes to the fault log
    always_comb begin
        log_clear = accept;
        log_rec   = hs & issue_fault;
        done      = done_q;
    end

    // Control state, pending set and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_valid) begin
                        pend <= en_mask;
                        if (en_mask == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (hs) begin
                        if (finish) begin
                            pend   <= '0;
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            pend <= pend_next;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Per-instruction context captured on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mode_q <= MODE_PRECISE;
            en_q   <= '0;
        end else if (accept) begin
            base_q <= start_base;
            mode_q <= start_defer ? MODE_DEFER : MODE_PRECISE;
            en_q   <= en_mask;
        end
    end

    // No new instruction can be taken while an element is on offer
    assert_no_start_while_issuing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !start_ready);

    // Only elements enabled at acceptance are ever offered
    assert_offer_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> en_q[issue_idx]);

    // A handshaken element is retired and never offered again
    assert_retired_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> !pend[$past(issue_idx)]);

    // Stalled offer holds its element
    assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !issue_ready |=> issue_valid && $stable(issue_idx));

    // A precise-mode fault halts issue and raises done next cycle
    assert_precise_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hs && issue_fault && (mode_q == MODE_PRECISE) |=> !issue_valid && done);

endmodule

// File: rtl/vec_elem_sequencer.sv
// Module: vec_elem_sequencer
// Top level of the predicated vector element issue sequencer. It turns one
// vector instruction into ordered per-element operations on contiguous
// registers. Masked or already-complete elements are skipped. Faults are
// reported with a precise stop or as a deferred mask.
// Assumes the downstream unit gives issue_fault in the same cycle it
// accepts an element, and that MAX_VL >= 2.
module vec_elem_sequencer #(
    parameter int MAX_VL = 32,
    parameter int REG_AW = 5,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int CNT_W = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [CNT_W-1:0]  start_vl,
    input  logic [REG_AW-1:0] start_base,
    input  logic [MAX_VL-1:0] start_pred,
    input  logic [MAX_VL-1:0] start_skip,
    input  logic              start_defer,
    output logic              issue_valid,
    input  logic              issue_ready,
    output logic [IDX_W-1:0]  issue_idx,
    output logic [REG_AW-1:0] issue_reg,
    input  logic              issue_fault,
    output logic              done,
    output logic              fault_flag,
    output logic [IDX_W-1:0]  fault_idx,
    output logic [MAX_VL-1:0] fault_mask
);

    logic [MAX_VL-1:0] en_mask;
    logic [MAX_VL-1:0] pend;
    logic [MAX_VL-1:0] pick_oh;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic              log_clear;
    logic              log_rec;

    vseq_enable_mask #(
        .N  (MAX_VL),
        .CW (CNT_W)
    ) u_enable (
        .vl   (start_vl),
        .pred (start_pred),
        .skip (start_skip),
        .en   (en_mask)
    );

    vseq_lowest_pick #(
        .N  (MAX_VL),
        .IW (IDX_W)
    ) u_pick (
        .req    (pend),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    vseq_ctrl #(
        .N  (MAX_VL),
        .IW (IDX_W),
        .AW (REG_AW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (start_valid),
        .start_ready (start_ready),
        .en_mask     (en_mask),
        .start_base  (start_base),
        .start_defer (start_defer),
        .issue_valid (issue_valid),
        .issue_ready (issue_ready),
        .issue_idx   (issue_idx),
        .issue_reg   (issue_reg),
        .issue_fault (issue_fault),
        .pend        (pend),
        .pick_any    (pick_any),
        .pick_idx    (pick_idx),
        .pick_oh     (pick_oh),
        .done        (done),
        .log_clear   (log_clear),
        .log_rec     (log_rec)
    );

    vseq_fault_log #(
        .N  (MAX_VL),
        .IW (IDX_W)
    ) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (log_clear),
        .rec        (log_rec),
        .rec_idx    (issue_idx),
        .fault_flag (fault_flag),
        .fault_idx  (fault_idx),
        .fault_mask (fault_mask)
    );

endmodule

// File: tb/vec_elem_sequencer_test.sv
`timescale 1ns/1ps
// Bench for vec_elem_sequencer: directed corner cases and then seeded random
// instructions, each compared against a model of the requirements.
module vec_elem_sequencer_test;

    localparam int NV = 32;
    localparam int AW = 5;
    localparam int IW = 5;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_valid = 1'b0;
    logic          start_ready;
    logic [CW-1:0] start_vl = '0;
    logic [AW-1:0] start_base = '0;
    logic [NV-1:0] start_pred = '0;
    logic [NV-1:0] start_skip = '0;
    logic          start_defer = 1'b0;
    logic          issue_valid;
    logic          issue_ready = 1'b0;
    logic [IW-1:0] issue_idx;
    logic [AW-1:0] issue_reg;
    logic          issue_fault = 1'b0;
    logic          done;
    logic          fault_flag;
    logic [IW-1:0] fault_idx;
    logic [NV-1:0] fault_mask;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    vec_elem_sequencer #(.MAX_VL(NV), .REG_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_vl(start_vl), .start_base(start_base),
        .start_pred(start_pred), .start_skip(start_skip),
        .start_defer(start_defer),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_idx(issue_idx), .issue_reg(issue_reg),
        .issue_fault(issue_fault), .done(done),
        .fault_flag(fault_flag), .fault_idx(fault_idx),
        .fault_mask(fault_mask)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                fails++;
                $display("FAIL R11 watchdog expired: actual %0d expected %0d", cycles, 150000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
                $finish;
            end
        end
    end

    // One instruction: drive it, follow every handshake, check the report
    task automatic run_instr(input int vl, input int base, input logic [NV-1:0] pred,
                             input logic [NV-1:0] skip, input bit defer,
                             input logic [NV-1:0] fpat, input int rpct, input bit timed);
        int explist[NV];
        int n = 0;
        int eidx = 0;
        bit efirst = 1'b1;
        logic [NV-1:0] emask = '0;
        int lim = (vl > NV) ? NV : vl;
        int ptr = 0;
        int cyc = 0;
        bit exp_done;
        bit fin = 1'b0;
        bit prev_stall = 1'b0;
        int prev_idx = 0;
        string ftag = defer ? "R10" : "R9";
        logic [NV-1:0] s_mask;
        logic [IW-1:0] s_idx;
        logic s_flag;
        for (int i = 0; i < lim; i++) begin
            if (pred[i] && !skip[i]) begin
                explist[n] = i;
                n++;
                if (fpat[i]) begin
                    emask[i] = 1'b1;
                    if (efirst) begin eidx = i; efirst = 1'b0; end
                    if (!defer) break;
                end
            end
        end
        @(negedge clk);
        start_vl = CW'(vl); start_base = AW'(base); start_pred = pred;
        start_skip = skip; start_defer = defer; start_valid = 1'b1;
        issue_ready = 1'b0; issue_fault = 1'b0;
        chk(start_ready == 1'b1, "R2", "start_ready before start", start_ready, 1);
        @(posedge clk);
        exp_done = (n == 0);
        while (!fin) begin
            @(negedge clk);
            start_valid = 1'b0;
            cyc++;
            if (done) begin
                chk(exp_done, "R11", "done timing", done, exp_done);
                chk(ptr == n, "R4", "elements issued", ptr, n);
                chk(fault_mask == emask, ftag, "fault_mask", fault_mask, emask);
                chk(fault_flag == (emask != 0), ftag, "fault_flag", fault_flag, emask != 0);
                chk(fault_idx == IW'(eidx), ftag, "fault_idx", fault_idx, eidx);
                chk(!issue_valid, "R4", "no offer at done", issue_valid, 0);
                if (n == 0) chk(cyc == 1, "R8", "empty done latency", cyc, 1);
                if (timed) chk(cyc == n + 1, "R7", "cycles to done", cyc, n + 1);
                fin = 1'b1;
            end else if (exp_done) begin
                chk(1'b0, "R11", "done missing", done, 1);
                fin = 1'b1;
            end else if (cyc > 600) begin
                chk(1'b0, "R11", "instruction never ended", cyc, n + 1);
                fin = 1'b1;
            end else begin
                chk(!start_ready, "R2", "start_ready while busy", start_ready, 0);
                if (issue_valid) begin
                    if (ptr >= n) begin
                        chk(1'b0, "R5", "unexpected element offered", issue_idx, 0);
                        fin = 1'b1;
                    end else begin
                        if (prev_stall)
                            chk(int'(issue_idx) == prev_idx, "R12", "stalled idx", issue_idx, prev_idx);
                        if ($urandom_range(99) < rpct) begin
                            issue_ready = 1'b1;
                            chk(int'(issue_idx) == explist[ptr], "R4", "element order", issue_idx, explist[ptr]);
                            chk(issue_reg == AW'(base + explist[ptr]), "R3", "target register",
                                issue_reg, AW'(base + explist[ptr]));
                            issue_fault = fpat[issue_idx];
                            ptr++;
                            if (ptr == n) exp_done = 1'b1;
                            prev_stall = 1'b0;
                        end else begin
                            issue_ready = 1'b0;
                            issue_fault = 1'b0;
                            prev_stall = 1'b1;
                            prev_idx = int'(issue_idx);
                        end
                    end
                end else begin
                    issue_ready = ($urandom_range(1) == 1);
                    issue_fault = 1'b0;
                end
            end
        end
        issue_ready = 1'b0;
        issue_fault = 1'b0;
        s_mask = fault_mask; s_idx = fault_idx; s_flag = fault_flag;
        @(negedge clk);
        chk(!done, "R11", "done single cycle", done, 0);
        chk(fault_mask == s_mask && fault_idx == s_idx && fault_flag == s_flag,
            "R11", "report held", fault_mask, s_mask);
    endtask

    initial begin
        logic [NV-1:0] ok_set;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(start_ready == 1'b1, "R1", "start_ready", start_ready, 1);
        chk(!issue_valid, "R1", "issue_valid", issue_valid, 0);
        chk(!done, "R1", "done", done, 0);
        chk(!fault_flag && fault_mask == '0 && fault_idx == '0, "R1", "fault report", fault_mask, 0);

        // R8 zero count
        run_instr(0, 4, '1, '0, 1'b0, '1, 100, 1'b1);
        // R5 all-zero predicate
        run_instr(32, 0, '0, '0, 1'b1, '1, 100, 1'b1);
        // R7 dense run, ready always high
        run_instr(8, 1, '1, '0, 1'b0, '0, 100, 1'b1);
        // R7 sparse predicate takes no extra cycles
        run_instr(8, 2, 32'h0000_00A5, '0, 1'b0, '0, 100, 1'b1);
        // R9 precise fault at element 3
        run_instr(10, 0, '1, '0, 1'b0, 32'h0000_0208, 100, 1'b1);
        // R10 deferred faults at 2, 5, 9
        run_instr(12, 3, '1, '0, 1'b1, 32'h0000_0224, 100, 1'b1);
        // R6 rerun with completed elements suppressed
        ok_set = ~32'h0000_0224;
        run_instr(12, 3, '1, ok_set, 1'b1, '0, 100, 1'b1);
        // R3 register wrap
        run_instr(5, 30, '1, '0, 1'b0, '0, 100, 1'b1);
        // R4 count above maximum is clamped
        run_instr(40, 7, '1, '0, 1'b1, 32'h8000_0001, 100, 1'b1);
        // R12 heavy backpressure
        run_instr(20, 9, 32'h00F0_F0F3, '0, 1'b1, 32'h0000_0F00, 25, 1'b0);

        for (int k = 0; k < 300; k++) begin
            int vl = $urandom_range(40);
            int base = $urandom_range(31);
            int sel = $urandom_range(7);
            logic [NV-1:0] pred = (sel == 0) ? '0 : (sel == 1) ? '1 : $urandom;
            logic [NV-1:0] skip = ($urandom_range(2) == 0) ? ($urandom & $urandom) : '0;
            logic [NV-1:0] fpat = $urandom & $urandom & $urandom;
            bit defer = $urandom_range(1) == 1;
            int rs = $urandom_range(2);
            int rpct = (rs == 0) ? 100 : (rs == 1) ? 70 : 30;
            run_instr(vl, base, pred, skip, defer, fpat, rpct, rpct == 100);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule